// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O Memory

This block is a synchronous on-chip memory with one input bus for write data, one output bus for read data, and one shared command port. Every access moves two bus-width beats. The storage is organised as words twice the bus width, and one address selects one such pair. The design works at beat level, with one clock edge per beat. Commands are accepted only on even beats, so a new access can start every second edge.

A write command is followed by two data beats, each with its own active-low byte enables. The two beats are gathered into one wide word, and that word is committed to storage in a single update one beat after the second data beat. A read fetches one wide word and sends it out as two consecutive beats, lower half first.

Reads and writes can overlap. A read issued in the slot right after a write to the same address sees the pending data, merged byte by byte, so the host never observes stale contents.

Top module: `sio_b2_mem`

## Requirements
- R1: Each address selects a storage word of 2*DW bits. Bits [DW-1:0] are the lower beat and bits [2*DW-1:DW] are the upper beat. The address has AW bits.
- R2: The command strobe `ld_n` is active low. A command is taken only when `ld_n` is 0 on an even edge. The first rising edge after reset release is even, and parity alternates on every edge after that. At all other times the command inputs have no effect.
- R3: `rw` = 1 selects a read and `rw` = 0 selects a write.
- R4: For a write accepted at edge n, `wdata` at edge n+1 fills the lower half and `wdata` at edge n+2 fills the upper half. The assembled word is written to storage in one update.
- R5: `wbe_n` is active low and is sampled with each data beat. Bit b enables `wdata[8b+7:8b]` of that beat. Disabled bytes keep their previous stored value.
- R6: For a read accepted at edge n, `rdata` carries the lower half after edge n+2 and the upper half after edge n+3, and `rvalid` is 1 for both beats. At all other times `rvalid` is 0 and `rdata` is 0. Reads issued in consecutive slots produce an unbroken stream.
- R7: A read accepted in the slot right after a write to the same address returns the write's enabled bytes. Its other bytes come from storage.
- R8: Reset drives `rvalid` and `rdata` to 0 and abandons in-flight commands. Stored contents are kept across reset.
- R9: Any mix of reads, writes and idle slots, in any order and to any addresses, runs without stalls and returns the data most recently written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_n | input | 1 | Active-low command strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Pair address |
| wdata | input | DW | Write data beat |
| wbe_n | input | DW/8 | Active-low byte enables for the current write beat |
| rdata | output | DW | Read data beat |
| rvalid | output | 1 | Marks a valid read beat |

## Verification
Directed passes cover several cases:
- Full-width fills of every address, which show whether the lower and upper halves are placed and returned in the right order.
- Sparse byte-enable patterns, which separate per-beat masking from per-command masking.
- Writes immediately followed by a read of the same address, which expose a missing or word-level-only forwarding path, with a different-address read as contrast.
- Strobes on odd beats and idle slots, which reveal any command taken off-slot.
- A reset between a write and a later read, which shows whether storage is retained.

Seeded random slots then mix all of these patterns back to back.

// File: rtl/sio_b2_pkg.sv
package sio_b2_pkg;

    localparam int  BYTE_W  = 8;
    localparam logic RW_READ = 1'b1;

    // progress of a write command through its two data beats
    typedef enum logic [1:0] {
        WA_IDLE = 2'd0,
        WA_LO   = 2'd1,
        WA_HI   = 2'd2
    } wa_state_e;

endpackage

// File: rtl/sio_b2_cmd.sv
module sio_b2_cmd
    import sio_b2_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW/8-1:0]   wbe_n,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    output logic              pend_vld,
    output logic [AW-1:0]     pend_addr,
    output logic [2*DW-1:0]   pend_data,
    output logic [DW/4-1:0]   pend_be
);
    localparam int NB = DW / BYTE_W;

    typedef struct packed {
        logic              phase;     // 0: even slot, command may be taken
        wa_state_e         wa;
        logic [AW-1:0]     wa_addr;
        logic [DW-1:0]     lo_data;
        logic [NB-1:0]     lo_be;
        logic              rd_req;
        logic [AW-1:0]     rd_addr;
        logic              pend_vld;
        logic [AW-1:0]     pend_addr;
        logic [2*DW-1:0]   pend_data;
        logic [2*NB-1:0]   pend_be;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    accept;

    always_comb begin
        st_d          = st_q;
        st_d.phase    = ~st_q.phase;
        st_d.rd_req   = 1'b0;
        st_d.pend_vld = 1'b0;
        accept        = !ld_n && !st_q.phase;

        case (st_q.wa)
            WA_LO: begin
                st_d.lo_data = wdata;
                st_d.lo_be   = ~wbe_n;
                st_d.wa      = WA_HI;
            end
            WA_HI: begin
                st_d.pend_vld  = 1'b1;
                st_d.pend_addr = st_q.wa_addr;
                st_d.pend_data = {wdata, st_q.lo_data};
                st_d.pend_be   = {~wbe_n, st_q.lo_be};
                st_d.wa        = WA_IDLE;
            end
            default: ;
        endcase

        if (accept) begin
            if (rw == RW_READ) begin
                st_d.rd_req  = 1'b1;
                st_d.rd_addr = addr;
            end else begin
                st_d.wa      = WA_LO;
                st_d.wa_addr = addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_req    = st_q.rd_req;
    assign rd_addr   = st_q.rd_addr;
    assign pend_vld  = st_q.pend_vld;
    assign pend_addr = st_q.pend_addr;
    assign pend_data = st_q.pend_data;
    assign pend_be   = st_q.pend_be;

    AST_RD_ON_EVEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_req |-> st_q.phase) else $error("read taken off-slot"); // R2
    AST_PEND_AFTER_BEAT2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_vld |-> st_q.phase) else $error("pending word misaligned"); // R4
    AST_PEND_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_vld |=> !st_q.pend_vld) else $error("pending word held"); // R4

endmodule

// File: rtl/sio_b2_array.sv
module sio_b2_array
    import sio_b2_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [2*DW-1:0]   wr_data,
    input  logic [DW/4-1:0]   wr_be,
    input  logic [AW-1:0]     rd_addr,
    output logic [2*DW-1:0]   rd_word
);
    localparam int LANES = 2 * DW / BYTE_W;
    localparam int DEPTH = 1 << AW;

    // one storage lane per byte of the wide word; not reset
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) lane_mem[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
        end

        assign rd_word[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/sio_b2_rdpath.sv
module sio_b2_rdpath
    import sio_b2_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    input  logic [2*DW-1:0]   arr_word,
    input  logic              pend_vld,
    input  logic [AW-1:0]     pend_addr,
    input  logic [2*DW-1:0]   pend_data,
    input  logic [DW/4-1:0]   pend_be,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);
    localparam int LANES = 2 * DW / BYTE_W;

    typedef struct packed {
        logic [2*DW-1:0] rbuf;
        logic            lo_due;
        logic            hi_due;
        logic [DW-1:0]   rdata;
        logic            rvalid;
    } rd_st_t;

    rd_st_t          st_d, st_q;
    logic            hit;
    logic [2*DW-1:0] merged;

    always_comb begin
        hit = pend_vld && (pend_addr == rd_addr);
        for (int b = 0; b < LANES; b++) begin
            merged[b*BYTE_W +: BYTE_W] = (hit && pend_be[b]) ?
                pend_data[b*BYTE_W +: BYTE_W] : arr_word[b*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.lo_due = 1'b0;
        st_d.hi_due = 1'b0;
        st_d.rvalid = 1'b0;
        st_d.rdata  = '0;
        if (st_q.lo_due) begin
            st_d.rdata  = st_q.rbuf[DW-1:0];
            st_d.rvalid = 1'b1;
            st_d.hi_due = 1'b1;
        end
        if (st_q.hi_due) begin
            st_d.rdata  = st_q.rbuf[2*DW-1:DW];
            st_d.rvalid = 1'b1;
        end
        if (rd_req) begin
            st_d.rbuf   = merged;
            st_d.lo_due = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

endmodule

// File: rtl/sio_b2_mem.sv
module sio_b2_mem
    import sio_b2_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW/8-1:0]   wbe_n,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);
    localparam int NB = DW / BYTE_W;

    logic              rd_req;
    logic [AW-1:0]     rd_addr;
    logic              pend_vld;
    logic [AW-1:0]     pend_addr;
    logic [2*DW-1:0]   pend_data;
    logic [2*NB-1:0]   pend_be;
    logic [2*DW-1:0]   arr_word;

    sio_b2_cmd #(.DW(DW), .AW(AW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_n      (ld_n),
        .rw        (rw),
        .addr      (addr),
        .wdata     (wdata),
        .wbe_n     (wbe_n),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_data (pend_data),
        .pend_be   (pend_be)
    );

    sio_b2_array #(.DW(DW), .AW(AW)) u_array (
        .clk     (clk),
        .wr_en   (pend_vld),
        .wr_addr (pend_addr),
        .wr_data (pend_data),
        .wr_be   (pend_be),
        .rd_addr (rd_addr),
        .rd_word (arr_word)
    );

    sio_b2_rdpath #(.DW(DW), .AW(AW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .arr_word  (arr_word),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_data (pend_data),
        .pend_be   (pend_be),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> ##1 rvalid ##1 rvalid) else $error("read beats missing"); // R6
    AST_NO_LONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |=> rvalid) else $error("single read beat"); // R6

endmodule

// File: tb/sim_sio_b2_mem.sv
`timescale 1ns/1ps
module sim_sio_b2_mem;
    localparam int DW    = 16;
    localparam int AW    = 4;
    localparam int NB    = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          rw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NB-1:0] wbe_n = '1;
    wire  [DW-1:0] rdata;
    wire           rvalid;

    sio_b2_mem #(.DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rvalid(rvalid)
    );

    always #4 clk = ~clk;

    logic [2*DW-1:0] mm [DEPTH];
    bit              expv [0:8191];
    logic [DW-1:0]   expd [0:8191];
    int    cyc = 0, nchk = 0, nfail = 0;
    string tag = "R8";
    bit    done = 1'b0;
    bit              pw_v = 1'b0;
    logic [AW-1:0]   pw_a;
    logic [2*DW-1:0] pw_d;
    logic [2*NB-1:0] pw_b;

    function automatic void model_write(input logic [AW-1:0] a, input logic [2*DW-1:0] d,
                                        input logic [2*NB-1:0] bn);
        for (int b = 0; b < 2*NB; b++)
            if (!bn[b]) mm[a][b*8 +: 8] = d[b*8 +: 8];
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
        nchk++;
        if (rvalid !== expv[cyc] || rdata !== expd[cyc]) begin
            nfail++;
            $display("FAIL %s edge %0d: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, cyc, rvalid, rdata, expv[cyc], expd[cyc]);
        end
        cyc++;
    endtask

    task automatic slot(input bit en, input bit rd, input logic [AW-1:0] a,
                        input logic [2*DW-1:0] d, input logic [2*NB-1:0] bn);
        ld_n = !en; rw = rd; addr = a;
        if (pw_v) begin
            wdata = pw_d[2*DW-1:DW]; wbe_n = pw_b[2*NB-1:NB];
            model_write(pw_a, pw_d, pw_b);
        end else begin
            wdata = DW'($urandom); wbe_n = NB'($urandom);
        end
        if (en && rd) begin
            expv[cyc+2] = 1'b1; expd[cyc+2] = mm[a][DW-1:0];
            expv[cyc+3] = 1'b1; expd[cyc+3] = mm[a][2*DW-1:DW];
        end
        tick();
        // odd beat: random strobes must be ignored (R2)
        ld_n = 1'($urandom); rw = 1'($urandom); addr = AW'($urandom);
        if (en && !rd) begin
            wdata = d[DW-1:0]; wbe_n = bn[NB-1:0];
        end else begin
            wdata = DW'($urandom); wbe_n = NB'($urandom);
        end
        tick();
        pw_v = en && !rd; pw_a = a; pw_d = d; pw_b = bn;
    endtask

    task automatic drain();
        slot(1'b0, 1'b0, '0, '0, '1);
        slot(1'b0, 1'b0, '0, '0, '1);
        slot(1'b0, 1'b1, '0, '0, '1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8192; i++) begin expv[i] = 1'b0; expd[i] = '0; end
        // R8: outputs quiet in reset
        tag = "R8";
        repeat (3) tick();
        rst_n = 1'b1;
        // R4 / R1: fill every address with full words, then read back in order
        tag = "R4";
        for (int a = 0; a < DEPTH; a++) slot(1'b1, 1'b0, AW'(a), {$urandom, 16'h0} ^ 32'(a * 32'h0101_0303), '0);
        drain();
        tag = "R1";
        for (int a = 0; a < DEPTH; a++) slot(1'b1, 1'b1, AW'(a), '0, '1);
        drain();
        // R5: per-beat byte enables
        tag = "R5";
        slot(1'b1, 1'b0, 4'd3, 32'hA1B2_C3D4, 4'b0101);
        slot(1'b1, 1'b0, 4'd4, 32'hFFFF_FFFF, 4'b1111);
        slot(1'b1, 1'b0, 4'd6, 32'h1357_9BDF, 4'b1000);
        slot(1'b0, 1'b0, '0, '0, '1);
        slot(1'b1, 1'b1, 4'd3, '0, '1);
        slot(1'b1, 1'b1, 4'd4, '0, '1);
        slot(1'b1, 1'b1, 4'd6, '0, '1);
        drain();
        // R7: forwarding on the slot right after a write
        tag = "R7";
        slot(1'b1, 1'b0, 4'd7, 32'hDEAD_BEEF, 4'b0110);
        slot(1'b1, 1'b1, 4'd7, '0, '1);
        slot(1'b1, 1'b0, 4'd8, 32'h0F0F_F0F0, 4'b0000);
        slot(1'b1, 1'b1, 4'd9, '0, '1);
        slot(1'b1, 1'b0, 4'd9, 32'h5555_AAAA, 4'b0011);
        slot(1'b1, 1'b1, 4'd9, '0, '1);
        drain();
        // R2: idle slots and a read with the strobe high
        tag = "R2";
        slot(1'b0, 1'b1, 4'd2, '0, '1);
        repeat (8) slot(1'b0, 1'b0, '0, '0, '1);
        slot(1'b1, 1'b1, 4'd2, '0, '1);
        drain();
        // R3: select polarity, alternating write/read
        tag = "R3";
        slot(1'b1, 1'b0, 4'd2, 32'h2468_ACE0, '0);
        slot(1'b1, 1'b1, 4'd2, '0, '1);
        slot(1'b1, 1'b0, 4'd2, 32'h1111_2222, '0);
        slot(1'b1, 1'b1, 4'd2, '0, '1);
        drain();
        // R6: unbroken back-to-back reads
        tag = "R6";
        for (int a = 0; a < 8; a++) slot(1'b1, 1'b1, AW'(a * 3), '0, '1);
        drain();
        // R8: contents survive reset
        tag = "R8";
        slot(1'b1, 1'b0, 4'd5, 32'hC0DE_F00D, '0);
        drain();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        pw_v = 1'b0;
        slot(1'b1, 1'b1, 4'd5, '0, '1);
        slot(1'b1, 1'b1, 4'd7, '0, '1);
        drain();
        // R9: random mix
        tag = "R9";
        for (int i = 0; i < 600; i++) begin
            bit en = ($urandom % 4) != 0;
            bit rd = 1'($urandom);
            logic [2*NB-1:0] bn = ($urandom % 3 == 0) ? '0 : (2*NB)'($urandom);
            slot(en, rd, AW'($urandom), $urandom, bn);
        end
        drain();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule